// File: doc/BRIEF.md
# CAN Frame Field Parser

This block sits behind the bit sampler and the destuffer of a CAN receiver. It takes one destuffed frame bit per strobe, together with that bit's position in the frame. Position 0 is the start-of-frame bit. From this stream it decodes standard and extended data and remote frames.

The identifier fields, the frame-type bits and the data length code are held on registers until the next start of frame. Each data byte is presented with a one-cycle strobe as soon as its last bit arrives. At the end of the frame the block reports the received CRC and checks it against a CRC-15 that it computes itself. It also reports the acknowledge slot and gives a one-cycle frame-done pulse, which tells the upstream stages to go back to idle.

Three error flags are produced: a recessive start bit, a CRC mismatch, and a dominant delimiter.

Top module: `can_field_parser`

## Requirements
- R1: When the bit at index 0 is recessive (1), `sof_err` pulses for one cycle, in the cycle after that strobe. A dominant (0) start bit gives no pulse.
- R2: `base_id` collects bits 1 to 11, most significant bit first. Bit 13 sets `ide`: 0 marks a standard frame and 1 marks an extended frame.
- R3: In a standard frame, `rtr` takes bit 12, `rsv0` takes bit 14, and `dlc` takes bits 15 to 18, most significant bit first.
- R4: In an extended frame, `ext_id` takes bits 14 to 31, `rtr` takes bit 32, `rsv1` takes bit 33, `rsv0` takes bit 34, and `dlc` takes bits 35 to 38. `full_id` equals `base_id` shifted left by 18, ORed with `ext_id`.
- R5: The data field follows the DLC. Each byte arrives most significant bit first and is shown on `data_byte` with a `data_valid` pulse and a running `data_index`. A frame carries min(DLC, 8) bytes. A remote frame (`rtr` = 1) carries none, whatever its DLC.
- R6: The 15 bits after the data field appear on `crc_rx` with a `crc_valid` pulse. `crc_err` pulses with it when `crc_rx` differs from the CRC-15 computed over bits 0 through the last data bit. That CRC uses polynomial 0x4599 and starts from zero.
- R7: `delim_err` pulses when the CRC delimiter (CRC end + 1) or the ACK delimiter (CRC end + 3) is dominant.
- R8: At the ACK slot (CRC end + 2), `ack_valid` pulses and `ack_ok` is 1 when the slot bit is dominant and 0 when it is recessive.
- R9: `frame_done` pulses once, in the cycle after the seventh end-of-frame bit (CRC end + 10).
- R10: After reset every output is 0. No two of `hdr_valid`, `data_valid`, `crc_valid`, `ack_valid` and `frame_done` are ever high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Strobe for one destuffed frame bit |
| bit_val | input | 1 | Bit value, 0 dominant, 1 recessive |
| bit_idx | input | 7 | Bit position within the frame, 0 is start of frame |
| sof_err | output | 1 | Pulse: start-of-frame bit was recessive |
| hdr_valid | output | 1 | Pulse: last DLC bit decoded |
| ide | output | 1 | Frame type, 1 extended |
| rtr | output | 1 | Remote frame flag |
| rsv0 | output | 1 | Reserved bit 0 as received |
| rsv1 | output | 1 | Reserved bit 1 as received (extended only) |
| dlc | output | 4 | Data length code as received |
| base_id | output | 11 | Base identifier |
| ext_id | output | 18 | Identifier extension |
| full_id | output | 29 | Combined 29-bit identifier |
| data_valid | output | 1 | Pulse: data byte complete |
| data_index | output | 3 | Index of the byte on data_byte |
| data_byte | output | 8 | Completed data byte |
| crc_valid | output | 1 | Pulse: CRC field complete |
| crc_rx | output | 15 | Received CRC field |
| crc_err | output | 1 | Pulse: CRC mismatch |
| ack_valid | output | 1 | Pulse: ACK slot decoded |
| ack_ok | output | 1 | ACK slot was dominant |
| delim_err | output | 1 | Pulse: a delimiter was dominant |
| frame_done | output | 1 | Pulse: end of frame reached |

## Verification
Some properties are checked by the embedded assertions on every cycle:
- the strobes never overlap;
- a data byte never appears before the header is complete, or in a remote frame;
- the decoded byte count never exceeds eight;
- `sof_err`, `ack_ok` and `crc_err` agree with the bit that produced them.

Other behaviour only the directed frames can show:
- that the identifier and DLC land in the right fields for each frame type;
- that the trailing fields move with the DLC and with the remote flag;
- that a DLC above eight is clamped;
- that a corrupted CRC, a dominant delimiter and a missing ACK are each reported.

// File: rtl/can_fp_pkg.sv
package can_fp_pkg;

    localparam int BASE_ID_W   = 11;
    localparam int EXT_ID_W    = 18;
    localparam int FULL_ID_W   = BASE_ID_W + EXT_ID_W;
    localparam int DLC_W       = 4;
    localparam int BYTE_W      = 8;
    localparam int MAX_BYTES   = 8;
    localparam int BYTE_IDX_W  = $clog2(MAX_BYTES);
    localparam int CRC_W       = 15;
    localparam logic [CRC_W-1:0] CRC_POLY = 15'h4599;
    localparam int EOF_LEN     = 7;

    // Field positions that the decode depends on
    localparam int POS_BIT12   = 12;
    localparam int POS_IDE     = 13;
    localparam int POS_RSV0_S  = 14;
    localparam int STD_DLC_END = 18;
    localparam int EXT_ID_END  = 31;
    localparam int POS_RTR_X   = 32;
    localparam int POS_RSV1_X  = 33;
    localparam int POS_RSV0_X  = 34;
    localparam int EXT_DLC_END = 38;

    // Offsets of trailing fields from the first CRC bit
    localparam int OFF_CRC_END = CRC_W - 1;
    localparam int OFF_CDEL    = CRC_W;
    localparam int OFF_ACK     = CRC_W + 1;
    localparam int OFF_ADEL    = CRC_W + 2;
    localparam int OFF_EOF_END = CRC_W + 2 + EOF_LEN;

    typedef enum logic [2:0] {
        FLD_HEADER,
        FLD_DATA,
        FLD_CRC,
        FLD_CDEL,
        FLD_ACK,
        FLD_ADEL,
        FLD_EOF,
        FLD_IDLE
    } fld_e;

    typedef struct packed {
        logic                 ide;
        logic                 rtr;
        logic                 rsv0;
        logic                 rsv1;
        logic                 bit12;
        logic [DLC_W-1:0]     dlc;
        logic [BASE_ID_W-1:0] base_id;
        logic [EXT_ID_W-1:0]  ext_id;
    } hdr_t;

    function automatic logic [CRC_W-1:0] crc15_step(input logic [CRC_W-1:0] c,
                                                     input logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

    function automatic logic [DLC_W:0] payload_bytes(input logic [DLC_W-1:0] code,
                                                      input logic remote);
        if (remote)                           return '0;
        if (int'(code) > MAX_BYTES)           return (DLC_W+1)'(MAX_BYTES);
        return {1'b0, code};
    endfunction

endpackage

// File: rtl/can_crc15.sv
module can_crc15
    import can_fp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             feed,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            crc <= '0;
        end else if (feed) begin
            crc <= crc15_step(restart ? '0 : crc, din);
        end
    end
endmodule

// File: rtl/can_bit_shift.sv
module can_bit_shift #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (en) q <= {q[W-2:0], din};
    end
endmodule

// File: rtl/can_field_parser.sv
module can_field_parser
    import can_fp_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bit_valid,
    input  logic                  bit_val,
    input  logic [IDX_W-1:0]      bit_idx,
    output logic                  sof_err,
    output logic                  hdr_valid,
    output logic                  ide,
    output logic                  rtr,
    output logic                  rsv0,
    output logic                  rsv1,
    output logic [DLC_W-1:0]      dlc,
    output logic [BASE_ID_W-1:0]  base_id,
    output logic [EXT_ID_W-1:0]   ext_id,
    output logic [FULL_ID_W-1:0]  full_id,
    output logic                  data_valid,
    output logic [BYTE_IDX_W-1:0] data_index,
    output logic [BYTE_W-1:0]     data_byte,
    output logic                  crc_valid,
    output logic [CRC_W-1:0]      crc_rx,
    output logic                  crc_err,
    output logic                  ack_valid,
    output logic                  ack_ok,
    output logic                  delim_err,
    output logic                  frame_done
);
    localparam int PRE_W = BYTE_W - 1;
    localparam int CRS_W = CRC_W - 1;

    hdr_t             hdr;
    logic             hdr_done;
    logic [IDX_W-1:0] last_data;
    logic [IDX_W-1:0] crc_start;
    logic [IDX_W-1:0] dlc_end;
    logic [IDX_W-1:0] rel;
    logic [IDX_W-1:0] data_rel;
    fld_e             fld;
    logic [BYTE_IDX_W-1:0] byte_cnt;
    logic [DLC_W:0]   nbytes;
    logic [DLC_W-1:0] dlc_full;

    logic [CRC_W-1:0] crc_calc;
    logic [PRE_W-1:0] data_pre;
    logic [CRS_W-1:0] crc_pre;
    logic             start_bit;

    assign start_bit = bit_valid && (bit_idx == '0);
    assign dlc_end   = hdr.ide ? IDX_W'(EXT_DLC_END) : IDX_W'(STD_DLC_END);
    assign crc_start = last_data + 1'b1;
    assign rel       = bit_idx - crc_start;
    assign data_rel  = bit_idx - dlc_end;
    assign dlc_full  = {hdr.dlc[DLC_W-2:0], bit_val};
    assign nbytes    = payload_bytes(dlc_full, hdr.rtr);

    // Field the incoming bit belongs to
    always_comb begin
        if (!hdr_done || bit_idx == '0)               fld = FLD_HEADER;
        else if (bit_idx <= last_data)                fld = FLD_DATA;
        else if (int'(rel) <= OFF_CRC_END)            fld = FLD_CRC;
        else if (int'(rel) == OFF_CDEL)               fld = FLD_CDEL;
        else if (int'(rel) == OFF_ACK)                fld = FLD_ACK;
        else if (int'(rel) == OFF_ADEL)               fld = FLD_ADEL;
        else if (int'(rel) <= OFF_EOF_END)            fld = FLD_EOF;
        else                                          fld = FLD_IDLE;
    end

    can_crc15 u_crc (
        .clk     (clk),
        .rst     (rst),
        .restart (start_bit),
        .feed    (bit_valid && (fld == FLD_HEADER || fld == FLD_DATA)),
        .din     (bit_val),
        .crc     (crc_calc)
    );

    can_bit_shift #(.W(PRE_W)) u_data_sh (
        .clk (clk),
        .rst (rst),
        .en  (bit_valid && fld == FLD_DATA),
        .din (bit_val),
        .q   (data_pre)
    );

    can_bit_shift #(.W(CRS_W)) u_crc_sh (
        .clk (clk),
        .rst (rst),
        .en  (bit_valid && fld == FLD_CRC),
        .din (bit_val),
        .q   (crc_pre)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr        <= '0;
            hdr_done   <= 1'b0;
            last_data  <= '0;
            byte_cnt   <= '0;
            sof_err    <= 1'b0;
            hdr_valid  <= 1'b0;
            data_valid <= 1'b0;
            data_index <= '0;
            data_byte  <= '0;
            crc_valid  <= 1'b0;
            crc_rx     <= '0;
            crc_err    <= 1'b0;
            ack_valid  <= 1'b0;
            ack_ok     <= 1'b0;
            delim_err  <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            sof_err    <= 1'b0;
            hdr_valid  <= 1'b0;
            data_valid <= 1'b0;
            crc_valid  <= 1'b0;
            crc_err    <= 1'b0;
            ack_valid  <= 1'b0;
            delim_err  <= 1'b0;
            frame_done <= 1'b0;
            if (bit_valid) begin
                unique case (fld)
                    FLD_HEADER: begin
                        if (bit_idx == '0) begin
                            hdr      <= '0;
                            hdr_done <= 1'b0;
                            byte_cnt <= '0;
                            sof_err  <= bit_val;
                        end else if (int'(bit_idx) < POS_BIT12) begin
                            hdr.base_id <= {hdr.base_id[BASE_ID_W-2:0], bit_val};
                        end else if (int'(bit_idx) == POS_BIT12) begin
                            hdr.bit12 <= bit_val;
                        end else if (int'(bit_idx) == POS_IDE) begin
                            hdr.ide <= bit_val;
                            if (!bit_val) hdr.rtr <= hdr.bit12;
                        end else if (!hdr.ide) begin
                            if (int'(bit_idx) == POS_RSV0_S) hdr.rsv0 <= bit_val;
                            else                             hdr.dlc  <= dlc_full;
                        end else begin
                            if (int'(bit_idx) <= EXT_ID_END)
                                hdr.ext_id <= {hdr.ext_id[EXT_ID_W-2:0], bit_val};
                            else if (int'(bit_idx) == POS_RTR_X)  hdr.rtr  <= bit_val;
                            else if (int'(bit_idx) == POS_RSV1_X) hdr.rsv1 <= bit_val;
                            else if (int'(bit_idx) == POS_RSV0_X) hdr.rsv0 <= bit_val;
                            else                                  hdr.dlc  <= dlc_full;
                        end
                        if (bit_idx == dlc_end) begin
                            hdr_done  <= 1'b1;
                            hdr_valid <= 1'b1;
                            last_data <= dlc_end + IDX_W'({nbytes, 3'b000});
                        end
                    end
                    FLD_DATA: begin
                        if (data_rel[2:0] == 3'd0) begin
                            data_valid <= 1'b1;
                            data_byte  <= {data_pre, bit_val};
                            data_index <= byte_cnt;
                            byte_cnt   <= byte_cnt + 1'b1;
                        end
                    end
                    FLD_CRC: begin
                        if (int'(rel) == OFF_CRC_END) begin
                            crc_valid <= 1'b1;
                            crc_rx    <= {crc_pre, bit_val};
                            crc_err   <= ({crc_pre, bit_val} != crc_calc);
                        end
                    end
                    FLD_CDEL, FLD_ADEL: delim_err <= ~bit_val;
                    FLD_ACK: begin
                        ack_valid <= 1'b1;
                        ack_ok    <= ~bit_val;
                    end
                    FLD_EOF: frame_done <= (int'(rel) == OFF_EOF_END);
                    default: ;
                endcase
            end
        end
    end

    assign ide     = hdr.ide;
    assign rtr     = hdr.rtr;
    assign rsv0    = hdr.rsv0;
    assign rsv1    = hdr.rsv1;
    assign dlc     = hdr.dlc;
    assign base_id = hdr.base_id;
    assign ext_id  = hdr.ext_id;
    assign full_id = {hdr.base_id, hdr.ext_id};

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hdr_valid, data_valid, crc_valid, ack_valid, frame_done})); // R10
    AST_SOF_ERR_SOURCE: assert property (@(posedge clk) disable iff (rst)
        sof_err |-> $past(bit_valid && bit_idx == '0 && bit_val)); // R1
    AST_DATA_AFTER_HDR: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> (hdr_done && !hdr.rtr)); // R5
    AST_BYTE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |-> (int'(last_data - dlc_end) <= MAX_BYTES * BYTE_W)); // R5
    AST_ACK_MATCHES_BIT: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> (ack_ok == !$past(bit_val))); // R8
    AST_CRC_ERR_WITH_FIELD: assert property (@(posedge clk) disable iff (rst)
        crc_err |-> crc_valid); // R6
endmodule

// File: tb/can_field_parser_bench.sv
module can_field_parser_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_valid = 1'b0;
    logic        bit_val = 1'b1;
    logic [6:0]  bit_idx = '0;
    logic        sof_err, hdr_valid, ide, rtr, rsv0, rsv1;
    logic [3:0]  dlc;
    logic [10:0] base_id;
    logic [17:0] ext_id;
    logic [28:0] full_id;
    logic        data_valid;
    logic [2:0]  data_index;
    logic [7:0]  data_byte;
    logic        crc_valid;
    logic [14:0] crc_rx;
    logic        crc_err, ack_valid, ack_ok, delim_err, frame_done;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    can_field_parser u_can_field_parser (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_val(bit_val), .bit_idx(bit_idx),
        .sof_err(sof_err), .hdr_valid(hdr_valid), .ide(ide), .rtr(rtr), .rsv0(rsv0),
        .rsv1(rsv1), .dlc(dlc), .base_id(base_id), .ext_id(ext_id), .full_id(full_id),
        .data_valid(data_valid), .data_index(data_index), .data_byte(data_byte),
        .crc_valid(crc_valid), .crc_rx(crc_rx), .crc_err(crc_err), .ack_valid(ack_valid),
        .ack_ok(ack_ok), .delim_err(delim_err), .frame_done(frame_done)
    );

    // Event capture, cumulative
    int          m_bytes = 0, m_done = 0, m_crcerr = 0, m_sof = 0, m_delim = 0, m_ack = 0;
    int          m_order_bad = 0;
    logic        m_ackval = 1'b0;
    logic [14:0] m_crc = '0;
    logic [7:0]  m_byte [64];

    always @(negedge clk) begin
        if (!rst) begin
            if (data_valid) begin
                m_byte[m_bytes % 64] = data_byte;
                m_bytes++;
            end
            if (frame_done) m_done++;
            if (crc_err)    m_crcerr++;
            if (sof_err)    m_sof++;
            if (delim_err)  m_delim++;
            if (ack_valid) begin m_ack++; m_ackval = ack_ok; end
            if (crc_valid)  m_crc = crc_rx;
            if (data_valid && crc_valid) m_order_bad++;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [14:0] ref_crc(input logic f [0:127], input int n);
        logic [14:0] c = '0;
        for (int i = 0; i < n; i++) begin
            logic t = f[i] ^ c[14];
            c = {c[13:0], 1'b0};
            if (t) c = c ^ 15'h4599;
        end
        return c;
    endfunction

    // Builds and sends one frame, then checks every decoded field.
    task automatic run_frame(input bit ext, input logic [10:0] id, input logic [17:0] eid,
                             input bit rem, input logic [3:0] code, input logic [63:0] pay,
                             input bit rsv, input bit bad_sof, input bit bad_crc,
                             input bit bad_delim, input bit nack, input string tag);
        logic f [0:127];
        int p = 0;
        int nb;
        int b0 = m_bytes, d0 = m_done, c0 = m_crcerr, s0 = m_sof, l0 = m_delim, a0 = m_ack;
        logic [14:0] crc_ref;
        for (int i = 0; i < 128; i++) f[i] = 1'b1;
        f[p++] = bad_sof;
        for (int i = 10; i >= 0; i--) f[p++] = id[i];
        f[p++] = ext ? 1'b1 : rem;
        f[p++] = ext;
        if (ext) begin
            for (int i = 17; i >= 0; i--) f[p++] = eid[i];
            f[p++] = rem;
            f[p++] = rsv;
        end
        f[p++] = rsv;
        for (int i = 3; i >= 0; i--) f[p++] = code[i];
        nb = rem ? 0 : (code > 8 ? 8 : int'(code));
        for (int k = 0; k < nb; k++)
            for (int i = 7; i >= 0; i--) f[p++] = pay[63 - 8*k - (7 - i)];
        crc_ref = ref_crc(f, p);
        for (int i = 14; i >= 0; i--) f[p++] = crc_ref[i] ^ (bad_crc && i == 0);
        f[p++] = ~bad_delim;
        f[p++] = nack;
        f[p++] = 1'b1;
        for (int i = 0; i < 7; i++) f[p++] = 1'b1;
        for (int i = 0; i < p; i++) begin
            @(negedge clk);
            bit_valid = 1'b1; bit_val = f[i]; bit_idx = 7'(i);
            @(negedge clk);
            bit_valid = 1'b0; bit_val = 1'b1;
        end
        repeat (3) @(negedge clk);
        chk(base_id == id, {tag, " R2 base_id"}, base_id, id);
        chk(ide == ext, {tag, " R2 ide"}, ide, ext);
        chk(rtr == rem, {tag, " R3/R4 rtr"}, rtr, rem);
        chk(dlc == code, {tag, " R3/R4 dlc"}, dlc, code);
        chk(rsv0 == rsv, {tag, " R3 rsv0"}, rsv0, rsv);
        if (ext) begin
            chk(ext_id == eid, {tag, " R4 ext_id"}, ext_id, eid);
            chk(rsv1 == rsv, {tag, " R4 rsv1"}, rsv1, rsv);
            chk(full_id == ((29'(id) << 18) | 29'(eid)), {tag, " R4 full_id"},
                full_id, (29'(id) << 18) | 29'(eid));
        end
        chk(m_bytes - b0 == nb, {tag, " R5 byte count"}, m_bytes - b0, nb);
        for (int k = 0; k < nb && k < m_bytes - b0; k++)
            chk(m_byte[(b0 + k) % 64] == pay[63 - 8*k -: 8], {tag, " R5 byte value"},
                m_byte[(b0 + k) % 64], pay[63 - 8*k -: 8]);
        if (nb > 0)
            chk(data_index == 3'(nb - 1), {tag, " R5 last index"}, data_index, nb - 1);
        chk(m_crc == (crc_ref ^ 15'(bad_crc)), {tag, " R6 crc_rx"}, m_crc,
            crc_ref ^ 15'(bad_crc));
        chk(m_crcerr - c0 == int'(bad_crc), {tag, " R6 crc_err"}, m_crcerr - c0, bad_crc);
        chk(m_sof - s0 == int'(bad_sof), {tag, " R1 sof_err"}, m_sof - s0, bad_sof);
        chk(m_delim - l0 == int'(bad_delim), {tag, " R7 delim_err"}, m_delim - l0, bad_delim);
        chk(m_ack - a0 == 1 && m_ackval == !nack, {tag, " R8 ack"}, m_ackval, !nack);
        chk(m_done - d0 == 1, {tag, " R9 frame_done"}, m_done - d0, 1);
        chk(m_order_bad == 0, {tag, " R10 strobe overlap"}, m_order_bad, 0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({sof_err, hdr_valid, ide, rtr, rsv0, rsv1, dlc, base_id, ext_id, data_valid,
             data_byte, crc_valid, crc_rx, crc_err, ack_valid, ack_ok, delim_err,
             frame_done} == '0, "R10 reset state", base_id, 0);
    endtask

    task automatic t_std_data;
        run_frame(0, 11'h123, '0, 0, 4'd2, 64'hA55A_0000_0000_0000, 0, 0, 0, 0, 0, "std2");
    endtask
    task automatic t_ext_data;
        run_frame(1, 11'h4F1, 18'h2_ABCD, 0, 4'd3, 64'h0102_FF00_0000_0000, 1, 0, 0, 0, 0, "ext3");
    endtask
    task automatic t_std_remote;
        run_frame(0, 11'h7EE, '0, 1, 4'd4, 64'hFFFF_FFFF_0000_0000, 0, 0, 0, 0, 0, "remote");
    endtask
    task automatic t_ext_remote;
        run_frame(1, 11'h001, 18'h3_FFFF, 1, 4'd8, '0, 0, 0, 0, 0, 0, "xremote");
    endtask
    task automatic t_dlc_clamp;
        run_frame(0, 11'h055, '0, 0, 4'd12, 64'h0011_2233_4455_6677, 0, 0, 0, 0, 0, "dlc12");
    endtask
    task automatic t_zero_len;
        run_frame(0, 11'h400, '0, 0, 4'd0, '0, 0, 0, 0, 0, 0, "dlc0");
    endtask
    task automatic t_bad_crc;
        run_frame(0, 11'h2AA, '0, 0, 4'd1, 64'h8100_0000_0000_0000, 0, 0, 1, 0, 0, "badcrc");
    endtask
    task automatic t_bad_sof;
        run_frame(0, 11'h0F0, '0, 0, 4'd1, 64'h3C00_0000_0000_0000, 0, 1, 0, 0, 0, "badsof");
    endtask
    task automatic t_bad_delim_nack;
        run_frame(1, 11'h3C3, 18'h0_0001, 0, 4'd8, 64'hDEAD_BEEF_CAFE_F00D, 0, 0, 0, 1, 1, "delim");
    endtask

    initial begin
        t_reset();
        t_std_data();
        t_ext_data();
        t_std_remote();
        t_ext_remote();
        t_dlc_clamp();
        t_zero_len();
        t_bad_crc();
        t_bad_sof();
        t_bad_delim_nack();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule